// File: doc/BRIEF.md
# Dual-Edge Serial Frame Loader

This block receives a 208-bit configuration and brightness frame over two wires: a data line and a data clock. Both wires come from outside the chip. They are brought into the system-clock domain through two flip-flop synchronisers. Every transition of the data clock, rising or falling, moves one bit into a shift register. The first bit sent ends up at the top of the register. The top bit of the register is presented on a serial output, so that identical loaders can be chained.

There is no separate load pin. To transfer the register contents into the holding latches, the sender first leaves the data clock untouched, high or low, for a long quiet period. It then toggles the data line in a short pulse train. On the second high-to-low transition of that train, two things load at once:
- the top 16 bits go into a command latch, which is also broken out into named control fields;
- the remaining 192 bits go into twelve 16-bit channel words.

A one-cycle strobe marks each load. The quiet period is a parameter counted in system-clock cycles. The default of 27500 cycles equals 220 µs at 125 MHz.

Top module: `serial_frame_loader`

## Requirements
- R1: After reset, the command word, all command fields, all channel words, the serial output and the load strobe are all 0.
- R2: Each transition of the data clock, rising or falling, shifts the synchronised data-line value into bit 0 of the frame register. After a load, `cmd_word` holds the first 16 bits sent, first bit in bit 15. `chan_words[16*k+15:16*k]` holds frame bits 16k+15..16k, so channel 11 is the first word after the command and channel 0 is the last word sent.
- R3: `dout` shows frame-register bit 207. After 208+n clock transitions, it shows the (n+1)-th bit of the frame that was sent first.
- R4: The pulse train on the data line counts only once the data clock has been quiet for `IDLE_CYCLES` system-clock cycles, counted from the last detected transition. Pulses sent before that leave the latches unchanged.
- R5: The load happens on the second falling edge of the data line after the quiet period has been reached. The first falling edge alone changes nothing.
- R6: `latch_pulse` is high for exactly one cycle per load.
- R7: A data-clock transition in the middle of a pulse train discards the falls counted so far and restarts the quiet period. A full new quiet period and two new falls are then needed.
- R8: After a load, further data-line pulses do nothing until another full quiet period has passed. After that, a new pair of falls loads again from the current register contents.
- R9: The command fields decode `cmd_word` as follows:
  - `fast_edge` = bit 10
  - `gs_res` = bits 9:8
  - `gck_div` = bits 7:5
  - `wave_sel` = bit 4
  - `ext_clk` = bit 3
  - `pol_inv` = bit 2
  - `cnt_reset` = bit 1
  - `one_shot` = bit 0
- R10: Shifting new data does not change the latched outputs between loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dck_in | input | 1 | Serial data clock, asynchronous |
| din | input | 1 | Serial data line, asynchronous |
| dout | output | 1 | Cascade output, top bit of the frame register |
| cmd_word | output | CMD_W | Latched command word |
| fast_edge | output | 1 | Command bit 10 |
| gs_res | output | 2 | Command bits 9:8 |
| gck_div | output | 3 | Command bits 7:5 |
| wave_sel | output | 1 | Command bit 4 |
| ext_clk | output | 1 | Command bit 3 |
| pol_inv | output | 1 | Command bit 2 |
| cnt_reset | output | 1 | Command bit 1 |
| one_shot | output | 1 | Command bit 0 |
| chan_words | output | CHANNELS*CH_W | Latched channel words, channel k at [16k+15:16k] |
| latch_pulse | output | 1 | One-cycle strobe on each load |

## Verification
The bench targets the following corner cases, each of which a faulty design would get wrong in a visible way:
- **Early pulses.** Pulses sent before the quiet period is reached must be ignored. A design that counts falls too early would load a fresh frame before the sender intended.
- **Single fall.** A lone first fall must not load anything. A design that loads on the first fall would show the new words one pulse early.
- **Interrupted train.** A clock transition in the middle of a train must clear the counted falls. A design that keeps them would load after a single fall once the next quiet period is reached.
- **Pulses after a load.** Trailing pulses after a load must do nothing. If the quiet window were not restarted on a load, the strobe count would rise twice per train.
- **Word ordering.** Distinct patterns in every channel word catch a reversed word or bit order.
- **Cascade output.** The chain output is checked bit by bit after the frame has filled the register.

// File: rtl/serial_frame_loader.sv
module serial_frame_loader #(
  parameter int CMD_W         = 16,
  parameter int CH_W          = 16,
  parameter int CHANNELS      = 12,
  parameter int IDLE_CYCLES   = 27500,
  parameter int FALL_TO_LATCH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dck_in,
  input  logic                     din,
  output logic                     dout,
  output logic [CMD_W-1:0]         cmd_word,
  output logic                     fast_edge,
  output logic [1:0]               gs_res,
  output logic [2:0]               gck_div,
  output logic                     wave_sel,
  output logic                     ext_clk,
  output logic                     pol_inv,
  output logic                     cnt_reset,
  output logic                     one_shot,
  output logic [CHANNELS*CH_W-1:0] chan_words,
  output logic                     latch_pulse
);
  localparam int FRAME_W = CMD_W + CHANNELS * CH_W;
  localparam int CNT_W   = $clog2(IDLE_CYCLES + 1);
  localparam int FALL_W  = $clog2(FALL_TO_LATCH + 1);

  logic [2:0]         dck_s, din_s;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   idle_cnt;
  logic [FALL_W-1:0]  falls;

  wire dck_edge = dck_s[1] ^ dck_s[2];
  wire din_fall = !din_s[1] && din_s[2];
  wire armed    = (idle_cnt == CNT_W'(IDLE_CYCLES));
  wire fire     = armed && din_fall && !dck_edge && (falls == FALL_W'(FALL_TO_LATCH - 1));

  assign dout      = shreg[FRAME_W-1];
  assign fast_edge = cmd_word[10];
  assign gs_res    = cmd_word[9:8];
  assign gck_div   = cmd_word[7:5];
  assign wave_sel  = cmd_word[4];
  assign ext_clk   = cmd_word[3];
  assign pol_inv   = cmd_word[2];
  assign cnt_reset = cmd_word[1];
  assign one_shot  = cmd_word[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dck_s       <= '0;
      din_s       <= '0;
      shreg       <= '0;
      idle_cnt    <= '0;
      falls       <= '0;
      latch_pulse <= 1'b0;
      cmd_word    <= '0;
      chan_words  <= '0;
    end else begin
      dck_s       <= {dck_s[1:0], dck_in};
      din_s       <= {din_s[1:0], din};
      latch_pulse <= fire;
      if (dck_edge)
        shreg <= {shreg[FRAME_W-2:0], din_s[1]};
      if (dck_edge || fire)
        idle_cnt <= '0;
      else if (!armed)
        idle_cnt <= idle_cnt + 1'b1;
      if (!armed || fire || dck_edge)
        falls <= '0;
      else if (din_fall)
        falls <= falls + 1'b1;
      if (fire)
        {cmd_word, chan_words} <= shreg;
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |=> !latch_pulse); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_pulse |-> ($stable(chan_words) && $stable(cmd_word))); // R10
  AST_LATCH_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |-> $past(armed)); // R4
  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= CNT_W'(IDLE_CYCLES)); // R4
  AST_DOUT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dck_edge) |-> $stable(dout)); // R2
  AST_EDGE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    dck_edge |=> !latch_pulse); // R7
endmodule

// File: tb/test_serial_frame_loader.sv
module test_serial_frame_loader;
  localparam int IDLE = 200;
  localparam int FW   = 208;

  logic clk = 1'b0, rst_n = 1'b0, dck = 1'b0, din = 1'b0;
  logic dout, fast_edge, wave_sel, ext_clk, pol_inv, cnt_reset, one_shot, latch_pulse;
  logic [1:0] gs_res;
  logic [2:0] gck_div;
  logic [15:0] cmd_word;
  logic [191:0] chan_words;
  int checks = 0, fails = 0, strobes = 0, cycles = 0;

  always #4 clk = ~clk;

  serial_frame_loader #(.IDLE_CYCLES(IDLE)) i_serial_frame_loader (
    .clk(clk), .rst_n(rst_n), .dck_in(dck), .din(din), .dout(dout),
    .cmd_word(cmd_word), .fast_edge(fast_edge), .gs_res(gs_res), .gck_div(gck_div),
    .wave_sel(wave_sel), .ext_clk(ext_clk), .pol_inv(pol_inv), .cnt_reset(cnt_reset),
    .one_shot(one_shot), .chan_words(chan_words), .latch_pulse(latch_pulse));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && latch_pulse) strobes <= strobes + 1;
  end

  always @(posedge clk)
    if (cycles > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end

  task automatic check(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    din = b;
    wait_cyc(4);
    dck = ~dck;
    wait_cyc(4);
  endtask

  task automatic send_frame(logic [FW-1:0] f);
    for (int i = FW - 1; i >= 0; i--) send_bit(f[i]);
    din = 1'b0;
  endtask

  task automatic pulse();
    din = 1'b1;
    wait_cyc(10);
    din = 1'b0;
    wait_cyc(30);
  endtask

  function automatic logic [FW-1:0] make_frame(logic [15:0] cmd, logic [15:0] seed);
    logic [FW-1:0] f;
    f[FW-1 -: 16] = cmd;
    for (int k = 0; k < 12; k++) f[16*k +: 16] = seed ^ 16'(k * 16'h1357) ^ 16'(k << 12);
    return f;
  endfunction

  task automatic check_latched(string req, logic [FW-1:0] f);
    check(req, FW'(cmd_word), FW'(f[207:192]));
    check(req, FW'(chan_words), FW'(f[191:0]));
  endtask

  logic [FW-1:0] fa, fb, fc, fd, fe;

  task automatic t_reset();
    check("R1 cmd", FW'(cmd_word), '0);
    check("R1 chan", FW'(chan_words), '0);
    check("R1 dout/strobe", FW'({dout, latch_pulse}), '0);
  endtask

  task automatic t_basic_load();
    send_frame(fa);
    wait_cyc(IDLE + 20);
    pulse();
    check("R5 first fall no load", FW'(chan_words), '0);
    pulse();
    check_latched("R2 frame A mapping", fa);
    check("R6 one strobe cycle", FW'(strobes), FW'(1));
    pulse();
    pulse();
    check("R8 trailing pulses ignored", FW'(strobes), FW'(1));
    check_latched("R8 data kept", fa);
    wait_cyc(IDLE + 20);
    pulse();
    pulse();
    check("R8 reload after idle", FW'(strobes), FW'(2));
    check_latched("R8 reload same data", fa);
  endtask

  task automatic t_early_pulses();
    send_frame(fb);
    check_latched("R10 shift keeps latches", fa);
    wait_cyc(20);
    pulse();
    pulse();
    check_latched("R4 early pulses ignored", fa);
    wait_cyc(IDLE + 20);
    pulse();
    check_latched("R5 single fall", fa);
    pulse();
    check_latched("R4 load after idle", fb);
  endtask

  task automatic t_abort();
    send_frame(fc);
    wait_cyc(IDLE + 20);
    pulse();
    send_bit(1'b1);
    din = 1'b0;
    wait_cyc(IDLE + 20);
    pulse();
    check_latched("R7 aborted count cleared", fb);
    pulse();
    check_latched("R7 load after restart", {fc[206:0], 1'b1});
  endtask

  task automatic t_fields();
    send_frame(fe);
    wait_cyc(IDLE + 20);
    pulse();
    pulse();
    check("R9 fields", FW'({fast_edge, gs_res, gck_div, wave_sel, ext_clk, pol_inv, cnt_reset, one_shot}),
          FW'({1'b1, 2'b10, 3'b101, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}));
    check("R9 word", FW'(cmd_word), FW'(16'hF6AD));
  endtask

  task automatic t_cascade();
    send_frame(fd);
    check("R3 dout first bit", FW'(dout), FW'(fd[207]));
    send_bit(1'b0);
    check("R3 dout second bit", FW'(dout), FW'(fd[206]));
    send_bit(1'b1);
    check("R3 dout third bit", FW'(dout), FW'(fd[205]));
    send_bit(1'b0);
    check("R3 dout fourth bit", FW'(dout), FW'(fd[204]));
  endtask

  initial begin
    fa = make_frame(16'h0123, 16'hA5C3);
    fb = make_frame(16'h7E81, 16'h3C0F);
    fc = make_frame(16'h4B2D, 16'hF00D);
    fd = make_frame(16'hB000, 16'h9999);
    fe = make_frame(16'hF6AD, 16'h1234);
    wait_cyc(5);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(3);
    t_basic_load();
    t_early_pulses();
    t_abort();
    t_fields();
    t_cascade();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule